// File: doc/BRIEF.md
# Low-Side Gate Drive Qualification Logic

This block produces the six gate-drive commands of a low-side MOSFET pre-driver. Each channel can be switched on from two sources: a parallel input pin, or a bit in a serially written gate-select register. The two sources are ORed. The result is then qualified by the power-on reset, two global enable inputs and a per-channel latch that records a shorted load.

The two enables act with different reach. The output enable only blanks the gate outputs and leaves every register as it is. The soft-reset enable does more. It blanks the outputs, clears the gate-select and shorted-load state, asserts the flag reset, drops the timer clock enable, and refuses new gate-select data. A general configuration register stays writable while the soft-reset enable is low.

Every output is registered on the system clock. A gate therefore changes one cycle after the register state and inputs that qualify it.

Top module: `gd_gate_ctrl`

## Requirements
- R1: While `rst` (synchronous, active high, the power-on reset) is sampled high, the next edge clears `sel_q`, `short_q`, `cfg_q` and `gate_out` to zero, sets `tmr_en` to 0 and sets `flag_rst` to 1.
- R2: With both enables high and channel i not latched shorted, `gate_out[i]` equals `par_in[i] | sel_q[i]` one clock after those values are present. Bit i of every vector belongs to channel i.
- R3: `out_en` low at an edge drives all of `gate_out` to 0 at that edge. It leaves `sel_q`, `short_q` and `cfg_q` unchanged.
- R4: `soft_en` low at an edge drives all of `gate_out` to 0 at that edge and clears `sel_q` and `short_q`.
- R5: While `soft_en` is low, a `sel_wr` strobe is ignored and `sel_q` stays 0. A `cfg_wr` strobe still loads `cfg_wr_data` into `cfg_q`.
- R6: Once both enables are high again, `gate_out` follows the current `par_in` and `sel_q` with the one-cycle latency of R2.
- R7: A high `short_evt[i]` sets `short_q[i]` at the next edge. `short_q[i]` then holds, and while it is set `gate_out[i]` is 0 from the following edge on.
- R8: `fault_clr` clears every bit of `short_q` at the next edge. A `short_evt` bit that is high in the same cycle wins for its channel, so that bit is set.
- R9: A `sel_wr` strobe with `soft_en` high loads `sel_wr_data` into `sel_q` at the next edge.
- R10: `tmr_en` equals `soft_en` and `flag_rst` equals `!soft_en`, both one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| soft_en | input | 1 | Soft-reset enable; low blanks gates and clears state |
| out_en | input | 1 | Output enable; low blanks gates only |
| par_in | input | 6 | Parallel gate request per channel |
| sel_wr | input | 1 | Gate-select register write strobe |
| sel_wr_data | input | 6 | Gate-select write data |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_wr_data | input | 6 | Configuration write data |
| short_evt | input | 6 | Shorted-load detect event per channel |
| fault_clr | input | 1 | Clears the shorted-load latches |
| gate_out | output | 6 | Registered gate-drive commands |
| sel_q | output | 6 | Gate-select register contents |
| short_q | output | 6 | Shorted-load latch state |
| cfg_q | output | 6 | Configuration register contents |
| tmr_en | output | 1 | Timer clock enable |
| flag_rst | output | 1 | Flag reset level |

## Verification
Register results are due at the first edge after the stimulus. These are `sel_q`, `short_q`, `cfg_q`, `tmr_en` and `flag_rst`, and `gate_out` when the change comes from the pins or enables. A gate change caused by a register write or a short event needs a second edge, because the gate flop reads the register that the first edge updated. The bench drives each stimulus on the falling edge and queues the expected values for the next rising edge. It compares a short delay after that edge, so one-edge results are checked at once. Two-edge results show up when the following queued item is checked.

// File: rtl/gd_pkg.sv
package gd_pkg;

    localparam int unsigned GD_CH = 6;

    typedef enum logic [1:0] {
        MODE_SOFT_RST = 2'd0,
        MODE_MUTED    = 2'd1,
        MODE_RUN      = 2'd2
    } gd_mode_e;

    typedef struct packed {
        logic soft_en;
        logic out_en;
    } gd_en_t;

    function automatic gd_mode_e gd_mode(input gd_en_t en);
        if (!en.soft_en)     return MODE_SOFT_RST;
        else if (!en.out_en) return MODE_MUTED;
        else                 return MODE_RUN;
    endfunction

endpackage

// File: rtl/gd_mode_ctl.sv
module gd_mode_ctl
    import gd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gd_en_t   en,
    output gd_mode_e mode,
    output logic     tmr_en,
    output logic     flag_rst
);

    assign mode = gd_mode(en);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_en   <= 1'b0;
            flag_rst <= 1'b1;
        end else begin
            tmr_en   <= (mode != MODE_SOFT_RST);
            flag_rst <= (mode == MODE_SOFT_RST);
        end
    end

    p_tmr_follow_r10: assert property (@(posedge clk) disable iff (rst)
        en.soft_en |=> (tmr_en && !flag_rst));
    p_flag_follow_r10: assert property (@(posedge clk) disable iff (rst)
        !en.soft_en |=> (!tmr_en && flag_rst));
    p_reset_r1: assert property (@(posedge clk)
        rst |=> (!tmr_en && flag_rst));

endmodule

// File: rtl/gd_sel_reg.sv
module gd_sel_reg
    import gd_pkg::*;
#(
    parameter int unsigned N_CH = GD_CH
) (
    input  logic            clk,
    input  logic            rst,
    input  gd_mode_e        mode,
    input  logic            sel_wr,
    input  logic [N_CH-1:0] sel_wr_data,
    input  logic            cfg_wr,
    input  logic [N_CH-1:0] cfg_wr_data,
    output logic [N_CH-1:0] sel_q,
    output logic [N_CH-1:0] cfg_q
);

    always_ff @(posedge clk) begin
        if (rst)                        sel_q <= '0;
        else if (mode == MODE_SOFT_RST) sel_q <= '0;
        else if (sel_wr)                sel_q <= sel_wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_wr) cfg_q <= cfg_wr_data;
    end

    p_sel_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SOFT_RST) |=> (sel_q == '0));
    p_sel_load_r9: assert property (@(posedge clk) disable iff (rst)
        (sel_wr && mode != MODE_SOFT_RST) |=> (sel_q == $past(sel_wr_data)));
    p_cfg_load_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (cfg_q == $past(cfg_wr_data)));
    p_sel_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_MUTED && !sel_wr) |=> $stable(sel_q));

endmodule

// File: rtl/gd_short_latch.sv
module gd_short_latch
    import gd_pkg::*;
#(
    parameter int unsigned N_CH = GD_CH
) (
    input  logic            clk,
    input  logic            rst,
    input  gd_mode_e        mode,
    input  logic [N_CH-1:0] short_evt,
    input  logic            fault_clr,
    output logic [N_CH-1:0] short_q
);

    logic [N_CH-1:0] keep;

    assign keep = fault_clr ? '0 : short_q;

    always_ff @(posedge clk) begin
        if (rst)                        short_q <= '0;
        else if (mode == MODE_SOFT_RST) short_q <= '0;
        else                            short_q <= keep | short_evt;
    end

    p_short_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SOFT_RST) |=> (short_q == '0));
    p_short_set_r7: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_SOFT_RST) |=> ((short_q & $past(short_evt)) == $past(short_evt)));
    p_short_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (fault_clr && short_evt == '0) |=> (short_q == '0));

endmodule

// File: rtl/gd_gate_drv.sv
module gd_gate_drv
    import gd_pkg::*;
#(
    parameter int unsigned N_CH = GD_CH
) (
    input  logic            clk,
    input  logic            rst,
    input  gd_mode_e        mode,
    input  logic [N_CH-1:0] par_in,
    input  logic [N_CH-1:0] sel_q,
    input  logic [N_CH-1:0] short_q,
    output logic [N_CH-1:0] gate_out
);

    logic run;
    assign run = (mode == MODE_RUN);

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        logic req;
        assign req = par_in[i] | sel_q[i];

        always_ff @(posedge clk) begin
            if (rst) gate_out[i] <= 1'b0;
            else     gate_out[i] <= run & req & ~short_q[i];
        end

        p_short_blocks_r7: assert property (@(posedge clk) disable iff (rst)
            short_q[i] |=> !gate_out[i]);
        p_or_on_r2: assert property (@(posedge clk) disable iff (rst)
            (run && !short_q[i] && (par_in[i] || sel_q[i])) |=> gate_out[i]);
    end

    p_blank_r3: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_RUN) |=> (gate_out == '0));
    p_reset_gate_r1: assert property (@(posedge clk)
        rst |=> (gate_out == '0));

endmodule

// File: rtl/gd_gate_ctrl.sv
module gd_gate_ctrl
    import gd_pkg::*;
#(
    parameter int unsigned N_CH = GD_CH
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            soft_en,
    input  logic            out_en,
    input  logic [N_CH-1:0] par_in,
    input  logic            sel_wr,
    input  logic [N_CH-1:0] sel_wr_data,
    input  logic            cfg_wr,
    input  logic [N_CH-1:0] cfg_wr_data,
    input  logic [N_CH-1:0] short_evt,
    input  logic            fault_clr,
    output logic [N_CH-1:0] gate_out,
    output logic [N_CH-1:0] sel_q,
    output logic [N_CH-1:0] short_q,
    output logic [N_CH-1:0] cfg_q,
    output logic            tmr_en,
    output logic            flag_rst
);

    gd_en_t   en;
    gd_mode_e mode;

    assign en = '{soft_en: soft_en, out_en: out_en};

    gd_mode_ctl u_mode (
        .clk(clk), .rst(rst), .en(en), .mode(mode),
        .tmr_en(tmr_en), .flag_rst(flag_rst)
    );

    gd_sel_reg #(.N_CH(N_CH)) u_sel (
        .clk(clk), .rst(rst), .mode(mode),
        .sel_wr(sel_wr), .sel_wr_data(sel_wr_data),
        .cfg_wr(cfg_wr), .cfg_wr_data(cfg_wr_data),
        .sel_q(sel_q), .cfg_q(cfg_q)
    );

    gd_short_latch #(.N_CH(N_CH)) u_short (
        .clk(clk), .rst(rst), .mode(mode),
        .short_evt(short_evt), .fault_clr(fault_clr), .short_q(short_q)
    );

    gd_gate_drv #(.N_CH(N_CH)) u_gate (
        .clk(clk), .rst(rst), .mode(mode),
        .par_in(par_in), .sel_q(sel_q), .short_q(short_q),
        .gate_out(gate_out)
    );

endmodule

// File: tb/test_gd_gate_ctrl.sv
module test_gd_gate_ctrl;

    localparam int N = 6;

    typedef struct {
        string      tag;
        logic [N-1:0] gate, sel, shrt, cfg;
        logic       tmr, flg;
    } exp_t;

    logic clk = 1'b0;
    logic rst, soft_en, out_en, sel_wr, cfg_wr, fault_clr;
    logic [N-1:0] par_in, sel_wr_data, cfg_wr_data, short_evt;
    logic [N-1:0] gate_out, sel_q, short_q, cfg_q;
    logic tmr_en, flag_rst;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    exp_t q[$];

    logic [N-1:0] m_gate = '0, m_sel = '0, m_short = '0, m_cfg = '0;
    logic m_tmr = 1'b0, m_flg = 1'b1;

    always #10 clk = ~clk;

    gd_gate_ctrl i_gd_gate_ctrl (
        .clk(clk), .rst(rst), .soft_en(soft_en), .out_en(out_en),
        .par_in(par_in), .sel_wr(sel_wr), .sel_wr_data(sel_wr_data),
        .cfg_wr(cfg_wr), .cfg_wr_data(cfg_wr_data), .short_evt(short_evt),
        .fault_clr(fault_clr), .gate_out(gate_out), .sel_q(sel_q),
        .short_q(short_q), .cfg_q(cfg_q), .tmr_en(tmr_en), .flag_rst(flag_rst)
    );

    task automatic step(input string tag, input logic r, input logic es, input logic eo,
                        input logic [N-1:0] par, input logic sw, input logic [N-1:0] sd,
                        input logic [N-1:0] evt, input logic fc,
                        input logic cw, input logic [N-1:0] cd);
        exp_t e;
        @(negedge clk);
        rst = r; soft_en = es; out_en = eo; par_in = par; sel_wr = sw;
        sel_wr_data = sd; short_evt = evt; fault_clr = fc; cfg_wr = cw; cfg_wr_data = cd;
        if (r) begin
            m_gate = '0; m_sel = '0; m_short = '0; m_cfg = '0; m_tmr = 0; m_flg = 1;
        end else begin
            m_gate  = (es && eo) ? ((par | m_sel) & ~m_short) : '0;
            m_sel   = !es ? '0 : (sw ? sd : m_sel);
            m_short = !es ? '0 : ((fc ? '0 : m_short) | evt);
            if (cw) m_cfg = cd;
            m_tmr = es; m_flg = !es;
        end
        e.tag = tag; e.gate = m_gate; e.sel = m_sel; e.shrt = m_short;
        e.cfg = m_cfg; e.tmr = m_tmr; e.flg = m_flg;
        q.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (gate_out !== e.gate || sel_q !== e.sel || short_q !== e.shrt ||
                    cfg_q !== e.cfg || tmr_en !== e.tmr || flag_rst !== e.flg) begin
                    n_fail++;
                    $display("FAIL %s: got gate=%b sel=%b short=%b cfg=%b tmr=%b flg=%b exp gate=%b sel=%b short=%b cfg=%b tmr=%b flg=%b",
                             e.tag, gate_out, sel_q, short_q, cfg_q, tmr_en, flag_rst,
                             e.gate, e.sel, e.shrt, e.cfg, e.tmr, e.flg);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : driver
        step("R1 reset",            1, 1, 1, 6'b111111, 1, 6'b111111, 6'b111111, 0, 1, 6'b111111);
        step("R1 reset hold",       1, 1, 1, 6'b000000, 0, '0, '0, 0, 0, '0);
        step("R2 parallel on",      0, 1, 1, 6'b000101, 0, '0, '0, 0, 0, '0);
        step("R9 select write",     0, 1, 1, 6'b000101, 1, 6'b110000, '0, 0, 0, '0);
        step("R2 or of sources",    0, 1, 1, 6'b000101, 0, '0, '0, 0, 0, '0);
        step("R2 parallel drop",    0, 1, 1, 6'b000001, 0, '0, '0, 0, 0, '0);
        step("R3 output enable low",0, 1, 0, 6'b000001, 0, '0, '0, 0, 0, '0);
        step("R3 registers kept",   0, 1, 0, 6'b001111, 0, '0, '0, 0, 0, '0);
        step("R6 output enable up", 0, 1, 1, 6'b001111, 0, '0, '0, 0, 0, '0);
        step("R7 short latched",    0, 1, 1, 6'b001111, 0, '0, 6'b000001, 0, 0, '0);
        step("R7 short gates off",  0, 1, 1, 6'b001111, 0, '0, '0, 0, 0, '0);
        step("R7 short holds",      0, 1, 1, 6'b001111, 0, '0, '0, 0, 0, '0);
        step("R8 clear vs event",   0, 1, 1, 6'b001111, 0, '0, 6'b000100, 1, 0, '0);
        step("R8 after clear",      0, 1, 1, 6'b001111, 0, '0, '0, 0, 0, '0);
        step("R4 soft enable low",  0, 0, 1, 6'b001111, 1, 6'b111111, 6'b000010, 0, 1, 6'b101010);
        step("R5 select ignored",   0, 0, 1, 6'b001111, 1, 6'b011011, '0, 0, 1, 6'b010101);
        step("R10 timer held off",  0, 0, 1, 6'b001111, 0, '0, '0, 0, 0, '0);
        step("R6 soft enable up",   0, 1, 1, 6'b100001, 0, '0, '0, 0, 0, '0);
        step("R6 follow inputs",    0, 1, 1, 6'b100001, 1, 6'b000110, '0, 0, 0, '0);
        step("R6 follow select",    0, 1, 1, 6'b000000, 0, '0, '0, 0, 0, '0);
        step("R1 reset again",      1, 1, 1, 6'b111111, 0, '0, '0, 0, 0, '0);
        step("R2 after reset",      0, 1, 1, 6'b010000, 0, '0, '0, 0, 0, '0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule